// File: doc/BRIEF.md
# Paired-Page Translation Permission Checker

This block takes one translation entry that has already been found for an access and decides what that access may do. An entry covers two adjacent virtual pages of equal size. Each page has its own descriptor: an even one and an odd one. The block picks one descriptor by looking at the virtual address bit that sits at the page-size exponent. It then checks the access type and the current privilege level against that descriptor. The result is either a physical address with read, write and execute rights, or a 3-bit fault code.

The decision logic is combinational. The top module registers its outputs, so a result appears one clock after its inputs are presented. The descriptor layout has two modes. The wide (64-bit) layout carries the read-inhibit, execute-inhibit and restricted-privilege flags and a long page number. The narrow (32-bit) layout keeps only the low 32 bits of the descriptor and has none of those three flags. Searching for the entry, raising the exception and walking the page tables are done elsewhere.

Top module: `tlb_pair_check`

## Requirements
- R1: The block selects the descriptor with virtual address bit [PS]. When that bit is 0 it uses `even_i`; when it is 1 it uses `odd_i`.
- R2: Descriptor bit positions. V is bit 0, D is bit 1 and PLV is bits [3:2]. In wide mode (`mode64_i`=1), NR is bit 61, NX is bit 62, RPLV is bit 63, and the page number occupies bits [47:12]. In narrow mode (`mode64_i`=0), the page number occupies bits [31:12], physical bits [47:32] are zero, and NR, NX and RPLV are taken as 0 whatever bits 63:32 hold.
- R3: Result codes are 0 match, 3 invalid, 4 dirty fault, 5 read-inhibit, 6 execute-inhibit and 7 privilege error. The checks are applied in this priority order:
  1. V clear gives invalid.
  2. A fetch with NX set gives execute-inhibit.
  3. A load with NR set gives read-inhibit.
  4. A privilege failure gives privilege error.
  5. A store with D clear gives dirty fault.

  Codes 1 and 2 are never produced.
- R4: With RPLV=0, a privilege error occurs when `plv_i` is numerically greater than the entry PLV. With RPLV=1, a privilege error occurs whenever `plv_i` differs from the entry PLV.
- R5: On a match, physical address bits below PS come from the virtual address. Bits from PS upward come from the page number at bit 12, so page-number bits [PS-1:12] are discarded.
- R6: On a match, read is granted, write equals D and execute equals the inverse of NX. On any fault, the physical address and all three rights are zero.
- R7: Results appear exactly one clock after the inputs. While `rst_n` is low, the outputs hold code 3, address 0 and no rights.
- R8: Access codes on `acc_i` are 0 load, 1 store and 2 fetch. `ps_i` must be between 12 and 30. A reserved access code or an out-of-range PS is reported as an assertion error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| va_i | input | 48 | Virtual address of the access |
| ps_i | input | 6 | Page-size exponent (12 to 30) |
| acc_i | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| plv_i | input | 2 | Current privilege level (0 is most privileged) |
| even_i | input | 64 | Descriptor of the even page |
| odd_i | input | 64 | Descriptor of the odd page |
| mode64_i | input | 1 | 1 selects the wide descriptor layout, 0 the narrow one |
| code_o | output | 3 | Result code |
| pa_o | output | 48 | Physical address on a match, zero otherwise |
| rd_o | output | 1 | Read right |
| wr_o | output | 1 | Write right |
| ex_o | output | 1 | Execute right |

## Verification
There is no hidden state beyond the output register, so any internal fault shows at the ports in the cycle right after the offending input. A wrong descriptor pick appears as the page number of the other half of the pair. A misplaced mask boundary appears as flipped address bits just above or just below bit PS. A misordered priority chain appears as a fault code that names the weaker of two simultaneous violations. The directed cases stack several violations on one descriptor so that each priority step can be seen on its own, and a seeded sweep covers the rest of the input space.

// File: rtl/tlbpc_pkg.sv
package tlbpc_pkg;

  localparam int TLBPC_PAGE_SH = 12;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_BADADDR = 3'd1,
    RES_MISS    = 3'd2,
    RES_INVALID = 3'd3,
    RES_DIRTY   = 3'd4,
    RES_RD_INH  = 3'd5,
    RES_EX_INH  = 3'd6,
    RES_PRIV    = 3'd7
  } tlbpc_res_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } tlbpc_acc_e;

  typedef struct packed {
    logic       valid;
    logic       dirty;
    logic [1:0] plv;
    logic       rplv;
    logic       no_rd;
    logic       no_ex;
  } tlbpc_flags_t;

  // Mask covering the in-page offset of a 2**ps page.
  function automatic logic [63:0] tlbpc_low_mask(input logic [5:0] ps);
    return (64'd1 << ps) - 64'd1;
  endfunction

  // Privilege rule: exact match when restricted, otherwise ceiling.
  function automatic logic tlbpc_priv_bad(input logic rplv,
                                          input logic [1:0] cur,
                                          input logic [1:0] own);
    return rplv ? (cur != own) : (cur > own);
  endfunction

endpackage

// File: rtl/tlbpc_pick.sv
module tlbpc_pick
  import tlbpc_pkg::*;
#(
  parameter int VA_W     = 48,
  parameter int PA_W     = 48,
  parameter int DESC_W   = 64,
  parameter int PS_W     = 6,
  parameter int NARROW_W = 32
) (
  input  logic [VA_W-1:0]   va_i,
  input  logic [PS_W-1:0]   ps_i,
  input  logic [DESC_W-1:0] even_i,
  input  logic [DESC_W-1:0] odd_i,
  input  logic              mode64_i,
  output tlbpc_flags_t      flags_o,
  output logic [PA_W-1:0]   base_o
);
  localparam int RPLV_POS  = DESC_W - 1;
  localparam int NX_POS    = DESC_W - 2;
  localparam int NR_POS    = DESC_W - 3;
  localparam int NARROW_HI = (NARROW_W - 1 < PA_W - 1) ? NARROW_W - 1 : PA_W - 1;

  logic [VA_W-1:0]   va_shifted;
  logic              odd_sel;
  logic [DESC_W-1:0] desc;
  logic              unused_mid;

  assign va_shifted = va_i >> ps_i;
  assign odd_sel    = va_shifted[0];
  assign desc       = odd_sel ? odd_i : even_i;
  assign unused_mid = ^desc[NR_POS-1:PA_W];

  always_comb begin
    flags_o.valid = desc[0];
    flags_o.dirty = desc[1];
    flags_o.plv   = desc[3:2];
    // narrow layout carries none of the three extension flags
    flags_o.rplv  = mode64_i & desc[RPLV_POS];
    flags_o.no_ex = mode64_i & desc[NX_POS];
    flags_o.no_rd = mode64_i & desc[NR_POS];
  end

  for (genvar b = 0; b < PA_W; b++) begin : g_base
    if (b < TLBPC_PAGE_SH) begin : g_off
      assign base_o[b] = 1'b0;
    end else if (b <= NARROW_HI) begin : g_lo
      assign base_o[b] = desc[b];
    end else begin : g_hi
      assign base_o[b] = mode64_i & desc[b];
    end
  end

endmodule

// File: rtl/tlbpc_judge.sv
module tlbpc_judge
  import tlbpc_pkg::*;
(
  input  tlbpc_flags_t flags_i,
  input  logic [1:0]   acc_i,
  input  logic [1:0]   plv_i,
  output tlbpc_res_e   code_o,
  output logic         priv_fail_o
);
  tlbpc_acc_e acc;
  assign acc         = tlbpc_acc_e'(acc_i);
  assign priv_fail_o = tlbpc_priv_bad(flags_i.rplv, plv_i, flags_i.plv);

  always_comb begin
    if (!flags_i.valid)                            code_o = RES_INVALID;
    else if (acc == ACC_FETCH && flags_i.no_ex)    code_o = RES_EX_INH;
    else if (acc == ACC_LOAD && flags_i.no_rd)     code_o = RES_RD_INH;
    else if (priv_fail_o)                          code_o = RES_PRIV;
    else if (acc == ACC_STORE && !flags_i.dirty)   code_o = RES_DIRTY;
    else                                           code_o = RES_OK;
  end

endmodule

// File: rtl/tlbpc_compose.sv
module tlbpc_compose
  import tlbpc_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 48,
  parameter int PS_W = 6
) (
  input  logic [VA_W-1:0] va_i,
  input  logic [PS_W-1:0] ps_i,
  input  logic [PA_W-1:0] base_i,
  input  tlbpc_res_e      code_i,
  input  logic            dirty_i,
  input  logic            no_ex_i,
  output logic [PA_W-1:0] pa_o,
  output logic            rd_o,
  output logic            wr_o,
  output logic            ex_o
);
  logic [PA_W-1:0] off_mask;
  logic [PA_W-1:0] va_w;
  logic            hit;

  assign off_mask = PA_W'(tlbpc_low_mask(6'(ps_i)));
  assign va_w     = PA_W'(va_i);
  assign hit      = (code_i == RES_OK);

  always_comb begin
    pa_o = '0;
    rd_o = 1'b0;
    wr_o = 1'b0;
    ex_o = 1'b0;
    if (hit) begin
      pa_o = (base_i & ~off_mask) | (va_w & off_mask);
      rd_o = 1'b1;
      wr_o = dirty_i;
      ex_o = ~no_ex_i;
    end
  end

endmodule

// File: rtl/tlb_pair_check.sv
module tlb_pair_check
  import tlbpc_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 48,
  parameter int DESC_W = 64,
  parameter int PS_W   = 6,
  parameter int PS_MIN = 12,
  parameter int PS_MAX = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   va_i,
  input  logic [PS_W-1:0]   ps_i,
  input  logic [1:0]        acc_i,
  input  logic [1:0]        plv_i,
  input  logic [DESC_W-1:0] even_i,
  input  logic [DESC_W-1:0] odd_i,
  input  logic              mode64_i,
  output logic [2:0]        code_o,
  output logic [PA_W-1:0]   pa_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              ex_o
);
  localparam logic [PS_W-1:0] PS_LO = PS_W'(PS_MIN);
  localparam logic [PS_W-1:0] PS_HI = PS_W'(PS_MAX);

  tlbpc_flags_t    flags_w;
  logic [PA_W-1:0] base_w;
  tlbpc_res_e      code_w;
  logic            priv_fail_w;
  logic [PA_W-1:0] pa_w;
  logic            rd_w, wr_w, ex_w;

  tlbpc_pick #(.VA_W(VA_W), .PA_W(PA_W), .DESC_W(DESC_W), .PS_W(PS_W)) u_pick (
    .va_i(va_i), .ps_i(ps_i), .even_i(even_i), .odd_i(odd_i),
    .mode64_i(mode64_i), .flags_o(flags_w), .base_o(base_w)
  );

  tlbpc_judge u_judge (
    .flags_i(flags_w), .acc_i(acc_i), .plv_i(plv_i),
    .code_o(code_w), .priv_fail_o(priv_fail_w)
  );

  tlbpc_compose #(.VA_W(VA_W), .PA_W(PA_W), .PS_W(PS_W)) u_compose (
    .va_i(va_i), .ps_i(ps_i), .base_i(base_w), .code_i(code_w),
    .dirty_i(flags_w.dirty), .no_ex_i(flags_w.no_ex),
    .pa_o(pa_w), .rd_o(rd_w), .wr_o(wr_w), .ex_o(ex_w)
  );

  tlbpc_res_e      code_q;
  logic [PA_W-1:0] pa_q;
  logic            rd_q, wr_q, ex_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RES_INVALID;
      pa_q   <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      ex_q   <= 1'b0;
    end else begin
      code_q <= code_w;
      pa_q   <= pa_w;
      rd_q   <= rd_w;
      wr_q   <= wr_w;
      ex_q   <= ex_w;
    end
  end

  assign code_o = code_q;
  assign pa_o   = pa_q;
  assign rd_o   = rd_q;
  assign wr_o   = wr_q;
  assign ex_o   = ex_q;

  // Observation wires for the checks below
  logic [PA_W-1:0] chk_mask;
  logic [PA_W-1:0] chk_va;
  assign chk_mask = PA_W'(tlbpc_low_mask(6'(ps_i)));
  assign chk_va   = PA_W'(va_i);

  // R8
  ps_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_i >= PS_LO) && (ps_i <= PS_HI));

  // R8
  acc_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_i != 2'd3);

  // R6
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != RES_OK) |-> (pa_q == '0 && !rd_q && !wr_q && !ex_q));

  // R6
  match_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == RES_OK) |-> rd_q);

  // R3
  invalid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(flags_w.valid)) |-> (code_q == RES_INVALID));

  // R3
  never_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q != RES_BADADDR) && (code_q != RES_MISS));

  // R4
  priv_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && code_q == RES_PRIV) |-> $past(priv_fail_w));

  // R5
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && code_q == RES_OK) |->
      ((pa_q & $past(chk_mask)) == ($past(chk_va) & $past(chk_mask))));

  // R2
  narrow_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(mode64_i)) |->
      (code_q != RES_RD_INH && code_q != RES_EX_INH && pa_q[PA_W-1:32] == '0));

endmodule

// File: tb/tlb_pair_check_tb.sv
`timescale 1ns/1ps
module tlb_pair_check_tb;

  typedef struct {
    logic [2:0]  code;
    logic [47:0] pa;
    logic        r, w, x;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] va = '0;
  logic [5:0]  ps = 6'd12;
  logic [1:0]  acc = 2'd0;
  logic [1:0]  plv = 2'd0;
  logic [63:0] de = '0, dd = '0;
  logic        m64 = 1'b1;
  logic [2:0]  code;
  logic [47:0] pa;
  logic        rd, wr, ex;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  tlb_pair_check u_dut (
    .clk(clk), .rst_n(rst_n), .va_i(va), .ps_i(ps), .acc_i(acc), .plv_i(plv),
    .even_i(de), .odd_i(dd), .mode64_i(m64),
    .code_o(code), .pa_o(pa), .rd_o(rd), .wr_o(wr), .ex_o(ex)
  );

  function automatic logic [63:0] mk(input logic v, input logic d, input logic [1:0] lv,
                                     input logic rp, input logic nr, input logic nx,
                                     input logic [47:0] page);
    logic [63:0] r;
    r = '0;
    r[47:12] = page[47:12];
    r[0] = v; r[1] = d; r[3:2] = lv;
    r[61] = nr; r[62] = nx; r[63] = rp;
    return r;
  endfunction

  // Reference model written from the requirements
  function automatic exp_t model(input logic [47:0] a, input logic [5:0] p,
                                 input logic [1:0] ac, input logic [1:0] lv,
                                 input logic [63:0] ev, input logic [63:0] od,
                                 input logic wide, input string tag);
    exp_t e;
    logic [63:0] d;
    logic nr, nx, rp, bad;
    e.tag = tag;
    d  = a[p] ? od : ev;
    nr = wide && d[61];
    nx = wide && d[62];
    rp = wide && d[63];
    bad = rp ? (lv != d[3:2]) : (lv > d[3:2]);
    if (!d[0])                 e.code = 3'd3;
    else if (ac == 2 && nx)    e.code = 3'd6;
    else if (ac == 0 && nr)    e.code = 3'd5;
    else if (bad)              e.code = 3'd7;
    else if (ac == 1 && !d[1]) e.code = 3'd4;
    else                       e.code = 3'd0;
    e.pa = '0; e.r = 0; e.w = 0; e.x = 0;
    if (e.code == 3'd0) begin
      for (int b = 0; b < 48; b++) begin
        if (b < int'(p))                     e.pa[b] = a[b];
        else if (b >= 12 && (wide || b < 32)) e.pa[b] = d[b];
      end
      e.r = 1'b1; e.w = d[1]; e.x = !nx;
    end
    return e;
  endfunction

  task automatic compare(input exp_t e);
    n_checks++;
    if (code !== e.code || pa !== e.pa || {rd, wr, ex} !== {e.r, e.w, e.x}) begin
      n_fails++;
      $display("FAIL %s: code=%0d exp %0d pa=%h exp %h rwx=%b%b%b exp %b%b%b",
               e.tag, code, e.code, pa, e.pa, rd, wr, ex, e.r, e.w, e.x);
    end
  endtask

  // Driver: presents one access per cycle and records its expectation
  task automatic go(input string tag, input logic [47:0] a, input logic [5:0] p,
                    input logic [1:0] ac, input logic [1:0] lv,
                    input logic [63:0] ev, input logic [63:0] od, input logic wide);
    @(negedge clk);
    va = a; ps = p; acc = ac; plv = lv; de = ev; dd = od; m64 = wide;
    exp_q.push_back(model(a, p, ac, lv, ev, od, wide, tag));
  endtask

  // Monitor: one result is due just after the edge following each push (R7)
  always @(posedge clk) begin
    #1;
    if (exp_q.size() != 0) compare(exp_q.pop_front());
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    exp_t rst_e;
    logic [63:0] pe, po;
    repeat (3) @(posedge clk);
    #1;
    // R7 reset state
    rst_e.code = 3'd3; rst_e.pa = '0; rst_e.r = 0; rst_e.w = 0; rst_e.x = 0; rst_e.tag = "R7";
    compare(rst_e);
    @(negedge clk);
    rst_n = 1'b1;

    pe = mk(1, 1, 0, 0, 0, 0, 48'h0000_AAAA_A000);
    po = mk(1, 1, 0, 0, 0, 0, 48'h0000_5555_5000);
    // R1 even and odd halves, two page sizes
    go("R1", 48'h0000_4000_0abc, 6'd12, 2'd0, 2'd0, pe, po, 1);
    go("R1", 48'h0000_4000_1abc, 6'd12, 2'd0, 2'd0, pe, po, 1);
    go("R1", 48'h0001_0000_1234, 6'd16, 2'd0, 2'd0, pe, po, 1);
    go("R1", 48'h0002_0000_1234, 6'd16, 2'd0, 2'd0, pe, po, 1);

    // R5 masking of page-number bits below PS
    go("R5", 48'h0000_0013_5789, 6'd21, 2'd0, 2'd0,
       mk(1, 1, 0, 0, 0, 0, 48'h00AB_CDEF_F000), po, 1);
    go("R5", 48'h0000_7FFF_FFFF, 6'd30, 2'd0, 2'd0,
       pe, mk(1, 1, 0, 0, 0, 0, 48'hFFFF_FFFF_F000), 1);
    go("R5", 48'h0000_0000_0FFF, 6'd12, 2'd0, 2'd0,
       mk(1, 1, 0, 0, 0, 0, 48'hFFFF_FFFF_F000), po, 1);

    // R2 narrow layout drops NX/NR/RPLV and high page bits
    go("R2", 48'h0000_0000_0100, 6'd12, 2'd2, 2'd1,
       mk(1, 1, 2, 1, 1, 1, 48'hFFFF_1234_5000), po, 0);
    go("R2", 48'h0000_0000_0100, 6'd12, 2'd0, 2'd1,
       mk(1, 1, 2, 1, 1, 1, 48'hFFFF_1234_5000), po, 0);
    go("R2", 48'h0000_0000_0100, 6'd12, 2'd2, 2'd1,
       mk(1, 1, 2, 1, 1, 1, 48'hFFFF_1234_5000), po, 1);

    // R3 priority order with stacked violations
    go("R3", 48'h0, 6'd12, 2'd2, 2'd3, mk(0, 0, 0, 0, 1, 1, 48'h0000_1000_0000), po, 1);
    go("R3", 48'h0, 6'd12, 2'd2, 2'd3, mk(1, 0, 0, 0, 1, 1, 48'h0000_1000_0000), po, 1);
    go("R3", 48'h0, 6'd12, 2'd0, 2'd3, mk(1, 0, 0, 0, 1, 1, 48'h0000_1000_0000), po, 1);
    go("R3", 48'h0, 6'd12, 2'd1, 2'd3, mk(1, 0, 0, 0, 1, 1, 48'h0000_1000_0000), po, 1);
    go("R3", 48'h0, 6'd12, 2'd1, 2'd0, mk(1, 0, 0, 0, 1, 1, 48'h0000_1000_0000), po, 1);
    go("R3", 48'h0, 6'd12, 2'd2, 2'd0, mk(1, 1, 0, 0, 1, 0, 48'h0000_1000_0000), po, 1);

    // R4 privilege ceiling and exact match
    go("R4", 48'h0, 6'd14, 2'd0, 2'd2, mk(1, 1, 3, 0, 0, 0, 48'h0000_2000_0000), po, 1);
    go("R4", 48'h0, 6'd14, 2'd0, 2'd3, mk(1, 1, 2, 0, 0, 0, 48'h0000_2000_0000), po, 1);
    go("R4", 48'h0, 6'd14, 2'd0, 2'd2, mk(1, 1, 3, 1, 0, 0, 48'h0000_2000_0000), po, 1);
    go("R4", 48'h0, 6'd14, 2'd0, 2'd3, mk(1, 1, 3, 1, 0, 0, 48'h0000_2000_0000), po, 1);

    // R6 rights on a match
    go("R6", 48'h0000_0000_0040, 6'd12, 2'd0, 2'd0, mk(1, 0, 0, 0, 0, 1, 48'h0000_3000_0000), po, 1);
    go("R6", 48'h0000_0000_0040, 6'd12, 2'd1, 2'd0, mk(1, 1, 0, 0, 0, 0, 48'h0000_3000_0000), po, 1);

    // R8 sweep over legal inputs, all rules together
    for (int i = 0; i < 300; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      a[0] = ($urandom_range(3, 0) != 0);
      b[0] = ($urandom_range(3, 0) != 0);
      go("R8", {$urandom, $urandom}, 6'($urandom_range(30, 12)),
         2'($urandom_range(2, 0)), 2'($urandom_range(3, 0)), a, b,
         1'($urandom_range(1, 0)));
    end

    repeat (3) @(posedge clk);
    #2;
    if (exp_q.size() != 0) begin
      n_fails++;
      $display("FAIL R7: %0d results never observed, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule